// File: doc/BRIEF.md
# Flash sector locator

This block turns a byte offset inside a flash device into the sector that holds it. The device is split into up to four erase regions. They sit back to back from offset zero, and each region has its own block count and its own power-of-two sector length. The block walks the regions in order and adds up the block counts of the regions it passes. Inside the matching region it divides the remaining distance by a shift. It returns the sector index, the sector length and the sector's aligned base address, all registered one cycle after a lookup strobe.

Beside the lookup sits a per-sector erase-pending map. A mark strobe flags the sector that holds the presented offset. A clear strobe empties the whole map when an erase finishes. Every lookup also reports whether its sector is flagged, which is what a controller needs while an erase is suspended. A combinational error flag reports region configurations that cannot be used. When region 0 has a zero block count, a single uniform region described by two separate inputs is used in place of the region list.

Top module: `flash_sector_locator`

## Requirements
- R1: A result appears with `res_valid_o` high in exactly the cycle after `lookup_i` is sampled high. In any cycle without a lookup, `res_valid_o` is low and the previous result stays on the outputs.
- R2: The sector index is the sum of the block counts of all earlier active regions, plus the distance from the region start divided by the region's sector length. Regions are packed from offset 0 in index order.
- R3: `sec_len_o` is the matching region's sector length. `sec_base_o` is the offset with the low log2(length) bits cleared.
- R4: An offset at or beyond the total configured size gives `out_of_range_o` = 1, and the index, length and base are all 0 with `erasing_o` = 0.
- R5: The first region whose block count is 0 ends the list. Regions after it affect neither lookups nor `cfg_err_o`.
- R6: When region 0's block count is 0, a single region with `uni_count_i` blocks of `uni_len_i` bytes is used instead.
- R7: `cfg_err_o` is 1 if any active region's sector length is not a power of two, has any of bits 7..0 set (less than 256 bytes), or is 2^24 or more.
- R8: `cfg_err_o` is 1 if any active region's start address is not a multiple of that region's sector length.
- R9: `mark_i` flags the sector holding `offset_i`, taking effect at the next clock edge. A later lookup of any offset in a flagged sector returns `erasing_o` = 1, and a lookup in an unflagged sector returns 0.
- R10: `clear_i` empties the whole pending map and wins over a `mark_i` in the same cycle.
- R11: After reset, all outputs are 0 and the pending map is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_count_i | input | NREG*CNT_W | Block count per region, region r at bits [r*CNT_W +: CNT_W] |
| cfg_len_i | input | NREG*LEN_W | Sector length in bytes per region, region r at bits [r*LEN_W +: LEN_W] |
| uni_count_i | input | CNT_W | Block count of the uniform fallback region |
| uni_len_i | input | LEN_W | Sector length of the uniform fallback region |
| offset_i | input | ADDR_W | Byte offset to locate or mark |
| lookup_i | input | 1 | Query strobe |
| mark_i | input | 1 | Flag the sector of `offset_i` as erase-pending |
| clear_i | input | 1 | Empty the erase-pending map |
| res_valid_o | output | 1 | Result valid, one cycle after `lookup_i` |
| out_of_range_o | output | 1 | Looked-up offset lies beyond the configured size |
| sector_o | output | SEC_W | Sector index |
| sec_len_o | output | LEN_W | Sector length in bytes |
| sec_base_o | output | ADDR_W | Aligned base address of the sector |
| erasing_o | output | 1 | Sector was flagged erase-pending at lookup time |
| cfg_err_o | output | 1 | Active region configuration is invalid |

## Verification
The bench uses the default parameters: four regions, 10-bit block counts, a 25-bit length field and a 64-entry pending map. The 25-bit length field can hold a sector length of exactly 2^24, so the upper length limit can be tested. The main layout mixes sector lengths of 256 and 2048 bytes. This puts region borders at 0x800 and 0x1800, so the accumulated index and the shift-based division are tested on both sides of each border. The uniform layout is 16 sectors of 4 KiB. It tests the fallback path and the size limit at 0x10000. With 11 sectors in the main layout and a 64-entry map, every sector can be flagged.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
    // Smallest legal sector length is 2**FSL_MIN_LG bytes
    localparam int FSL_MIN_LG = 8;
    // Sector length must stay strictly below 2**FSL_MAX_LG bytes
    localparam int FSL_MAX_LG = 24;
endpackage

// File: rtl/fsl_region_walk.sv
module fsl_region_walk #(
    parameter int NREG   = 4,
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 10,
    parameter int LEN_W  = 25,
    parameter int SEC_W  = 12,
    parameter int SIZE_W = 35
) (
    input  logic [NREG-1:0]             act_i,
    input  logic [NREG-1:0][CNT_W-1:0]  cnt_i,
    input  logic [NREG-1:0][LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0]           offset_i,
    output logic [NREG-1:0][SIZE_W-1:0] base_o,
    output logic                        hit_o,
    output logic [SEC_W-1:0]            sector_o,
    output logic [LEN_W-1:0]            len_o,
    output logic [ADDR_W-1:0]           sec_base_o
);
    localparam int LG_W = $clog2(LEN_W);

    // Position of the highest set bit; exact for power-of-two lengths
    function automatic logic [LG_W-1:0] lg2(input logic [LEN_W-1:0] v);
        logic [LG_W-1:0] res;
        res = '0;
        for (int b = 0; b < LEN_W; b++) begin
            if (v[b]) res = LG_W'(b);
        end
        return res;
    endfunction

    logic [SIZE_W-1:0] acc;
    logic [SEC_W-1:0]  first;
    logic [SIZE_W-1:0] span;
    logic [SIZE_W-1:0] rel;
    logic [SIZE_W-1:0] off_w;
    logic [LG_W-1:0]   sh;

    always_comb begin
        acc        = '0;
        first      = '0;
        span       = '0;
        rel        = '0;
        sh         = '0;
        off_w      = SIZE_W'(offset_i);
        hit_o      = 1'b0;
        sector_o   = '0;
        len_o      = '0;
        sec_base_o = '0;
        base_o     = '0;
        for (int r = 0; r < NREG; r++) begin
            base_o[r] = acc;
            if (act_i[r]) begin
                sh   = lg2(len_i[r]);
                span = SIZE_W'(cnt_i[r]) << sh;
                if (!hit_o && (off_w >= acc) && (off_w < acc + span)) begin
                    rel        = off_w - acc;
                    hit_o      = 1'b1;
                    sector_o   = first + SEC_W'(rel >> sh);
                    len_o      = len_i[r];
                    sec_base_o = offset_i & ~ADDR_W'(len_i[r] - 1'b1);
                end
                acc   = acc + span;
                first = first + SEC_W'(cnt_i[r]);
            end
        end
    end
endmodule

// File: rtl/fsl_cfg_check.sv
module fsl_cfg_check
    import fsl_pkg::*;
#(
    parameter int NREG   = 4,
    parameter int LEN_W  = 25,
    parameter int SIZE_W = 35
) (
    input  logic [NREG-1:0]             act_i,
    input  logic [NREG-1:0][LEN_W-1:0]  len_i,
    input  logic [NREG-1:0][SIZE_W-1:0] base_i,
    output logic                        err_o
);
    logic [NREG-1:0] bad;

    for (genvar g = 0; g < NREG; g++) begin : g_region
        logic not_pow2, too_small, too_big, misaligned;
        assign not_pow2   = ($countones(len_i[g]) != 1);
        assign too_small  = (len_i[g][FSL_MIN_LG-1:0] != '0);
        assign too_big    = |(len_i[g] >> FSL_MAX_LG);
        assign misaligned = ((base_i[g] & SIZE_W'(len_i[g] - 1'b1)) != '0);
        assign bad[g]     = act_i[g] & (not_pow2 | too_small | too_big | misaligned);
    end

    assign err_o = |bad;
endmodule

// File: rtl/fsl_pending_map.sv
module fsl_pending_map #(
    parameter int DEPTH = 64,
    parameter int SEC_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [SEC_W-1:0] idx_i,
    output logic             bit_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] map_d, map_q;
    logic             in_map;
    logic [IDX_W-1:0] idx;

    assign in_map = (int'(idx_i) < DEPTH);
    assign idx    = idx_i[IDX_W-1:0];

    always_comb begin
        map_d = map_q;
        if (clr_i) begin
            map_d = '0;
        end else if (set_i && in_map) begin
            map_d[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) map_q <= '0;
        else         map_q <= map_d;
    end

    assign bit_o = in_map & map_q[idx];
endmodule

// File: rtl/flash_sector_locator.sv
module flash_sector_locator #(
    parameter int NREG      = 4,
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 10,
    parameter int LEN_W     = 25,
    parameter int MAP_DEPTH = 64
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NREG*CNT_W-1:0]    cfg_count_i,
    input  logic [NREG*LEN_W-1:0]    cfg_len_i,
    input  logic [CNT_W-1:0]         uni_count_i,
    input  logic [LEN_W-1:0]         uni_len_i,
    input  logic [ADDR_W-1:0]        offset_i,
    input  logic                     lookup_i,
    input  logic                     mark_i,
    input  logic                     clear_i,
    output logic                     res_valid_o,
    output logic                     out_of_range_o,
    output logic [CNT_W+$clog2(NREG)-1:0] sector_o,
    output logic [LEN_W-1:0]         sec_len_o,
    output logic [ADDR_W-1:0]        sec_base_o,
    output logic                     erasing_o,
    output logic                     cfg_err_o
);
    localparam int SEC_W  = CNT_W + $clog2(NREG);
    localparam int SIZE_W = CNT_W + LEN_W;

    typedef struct packed {
        logic              valid;
        logic              oor;
        logic [SEC_W-1:0]  sector;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] base;
        logic              erasing;
    } res_t;

    // Effective region list after uniform fallback and terminator
    logic                       use_uni;
    logic [NREG-1:0][CNT_W-1:0] eff_cnt;
    logic [NREG-1:0][LEN_W-1:0] eff_len;
    logic [NREG-1:0]            act;

    always_comb begin
        use_uni = (cfg_count_i[CNT_W-1:0] == '0);
        for (int r = 0; r < NREG; r++) begin
            if (use_uni) begin
                eff_cnt[r] = (r == 0) ? uni_count_i : '0;
                eff_len[r] = (r == 0) ? uni_len_i   : '0;
            end else begin
                eff_cnt[r] = cfg_count_i[r*CNT_W +: CNT_W];
                eff_len[r] = cfg_len_i[r*LEN_W +: LEN_W];
            end
            act[r] = (eff_cnt[r] != '0) && ((r == 0) ? 1'b1 : act[(r == 0) ? 0 : r-1]);
        end
    end

    logic [NREG-1:0][SIZE_W-1:0] reg_base;
    logic                        hit;
    logic [SEC_W-1:0]            w_sector;
    logic [LEN_W-1:0]            w_len;
    logic [ADDR_W-1:0]           w_base;
    logic                        pend_bit;

    fsl_region_walk #(
        .NREG(NREG), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .LEN_W(LEN_W), .SEC_W(SEC_W), .SIZE_W(SIZE_W)
    ) u_walk (
        .act_i     (act),
        .cnt_i     (eff_cnt),
        .len_i     (eff_len),
        .offset_i  (offset_i),
        .base_o    (reg_base),
        .hit_o     (hit),
        .sector_o  (w_sector),
        .len_o     (w_len),
        .sec_base_o(w_base)
    );

    fsl_cfg_check #(
        .NREG(NREG), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
    ) u_check (
        .act_i (act),
        .len_i (eff_len),
        .base_i(reg_base),
        .err_o (cfg_err_o)
    );

    fsl_pending_map #(
        .DEPTH(MAP_DEPTH), .SEC_W(SEC_W)
    ) u_map (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (mark_i & hit),
        .clr_i (clear_i),
        .idx_i (w_sector),
        .bit_o (pend_bit)
    );

    res_t res_d, res_q;

    always_comb begin
        res_d       = res_q;
        res_d.valid = lookup_i;
        if (lookup_i) begin
            res_d.oor     = ~hit;
            res_d.sector  = hit ? w_sector : '0;
            res_d.len     = hit ? w_len    : '0;
            res_d.base    = hit ? w_base   : '0;
            res_d.erasing = hit & pend_bit;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign res_valid_o    = res_q.valid;
    assign out_of_range_o = res_q.oor;
    assign sector_o       = res_q.sector;
    assign sec_len_o      = res_q.len;
    assign sec_base_o     = res_q.base;
    assign erasing_o      = res_q.erasing;
endmodule

// File: rtl/fsl_locator_chk.sv
module fsl_locator_chk #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 25,
    parameter int SEC_W  = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              lookup_i,
    input logic              clear_i,
    input logic [ADDR_W-1:0] offset_i,
    input logic              res_valid_o,
    input logic              out_of_range_o,
    input logic [SEC_W-1:0]  sector_o,
    input logic [LEN_W-1:0]  sec_len_o,
    input logic [ADDR_W-1:0] sec_base_o,
    input logic              erasing_o
);
    logic clr1_q, clr2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            clr1_q <= 1'b0;
            clr2_q <= 1'b0;
        end else begin
            clr1_q <= clear_i;
            clr2_q <= clr1_q;
        end
    end

    a_r1_valid_after_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lookup_i |=> res_valid_o);

    a_r1_quiet_without_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lookup_i |=> !res_valid_o);

    a_r1_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lookup_i |=> ($stable(sector_o) && $stable(sec_base_o) && $stable(sec_len_o)));

    a_r3_len_pow2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_o && !out_of_range_o) |-> ($countones(sec_len_o) == 1));

    a_r3_offset_inside_sector: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_o && !out_of_range_o) |->
            ((64'($past(offset_i)) >= 64'(sec_base_o)) &&
             (64'($past(offset_i)) - 64'(sec_base_o) < 64'(sec_len_o))));

    a_r4_oor_zeroed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_o && out_of_range_o) |->
            (sector_o == '0 && sec_len_o == '0 && sec_base_o == '0 && !erasing_o));

    a_r10_cleared_before_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_o && clr2_q) |-> !erasing_o);
endmodule

bind flash_sector_locator fsl_locator_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEC_W(SEC_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lookup_i      (lookup_i),
    .clear_i       (clear_i),
    .offset_i      (offset_i),
    .res_valid_o   (res_valid_o),
    .out_of_range_o(out_of_range_o),
    .sector_o      (sector_o),
    .sec_len_o     (sec_len_o),
    .sec_base_o    (sec_base_o),
    .erasing_o     (erasing_o)
);

// File: tb/flash_sector_locator_bench.sv
module flash_sector_locator_bench;
    localparam int NREG = 4, ADDR_W = 24, CNT_W = 10, LEN_W = 25, MAP_DEPTH = 64;
    localparam int SEC_W = CNT_W + $clog2(NREG);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NREG*CNT_W-1:0] cfg_count = '0;
    logic [NREG*LEN_W-1:0] cfg_len = '0;
    logic [CNT_W-1:0]  uni_count = '0;
    logic [LEN_W-1:0]  uni_len = '0;
    logic [ADDR_W-1:0] offset = '0;
    logic lookup = 1'b0, mark = 1'b0, clear = 1'b0;
    logic res_valid, oor, erasing, cfg_err;
    logic [SEC_W-1:0]  sector;
    logic [LEN_W-1:0]  sec_len;
    logic [ADDR_W-1:0] sec_base;

    always #5 clk = ~clk;

    flash_sector_locator #(
        .NREG(NREG), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .MAP_DEPTH(MAP_DEPTH)
    ) u_flash_sector_locator (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_count_i(cfg_count), .cfg_len_i(cfg_len),
        .uni_count_i(uni_count), .uni_len_i(uni_len),
        .offset_i(offset), .lookup_i(lookup), .mark_i(mark), .clear_i(clear),
        .res_valid_o(res_valid), .out_of_range_o(oor), .sector_o(sector),
        .sec_len_o(sec_len), .sec_base_o(sec_base), .erasing_o(erasing),
        .cfg_err_o(cfg_err)
    );

    typedef struct {
        string             tag;
        logic              oor;
        logic [SEC_W-1:0]  sector;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] base;
        logic              erasing;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0, n_fail = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected item per valid result
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " oor"},     longint'(oor),      longint'(e.oor));
                check({e.tag, " sector"},  longint'(sector),   longint'(e.sector));
                check({e.tag, " len"},     longint'(sec_len),  longint'(e.len));
                check({e.tag, " base"},    longint'(sec_base), longint'(e.base));
                check({e.tag, " erasing"}, longint'(erasing),  longint'(e.erasing));
            end
        end
    end

    task automatic do_lookup(input string tag, input logic [ADDR_W-1:0] off,
                             input logic e_oor, input int e_sec, input int e_len,
                             input int e_base, input logic e_er);
        exp_t e;
        e.tag = tag; e.oor = e_oor; e.sector = SEC_W'(e_sec);
        e.len = LEN_W'(e_len); e.base = ADDR_W'(e_base); e.erasing = e_er;
        @(negedge clk);
        exp_q.push_back(e);
        offset = off;
        lookup = 1'b1;
        @(negedge clk);
        lookup = 1'b0;
    endtask

    task automatic do_mark(input logic [ADDR_W-1:0] off, input logic with_clear);
        @(negedge clk);
        offset = off;
        mark = 1'b1;
        clear = with_clear;
        @(negedge clk);
        mark = 1'b0;
        clear = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic set_cfg(input int c0, input int l0, input int c1, input int l1,
                           input int c2, input int l2, input int c3, input int l3,
                           input int uc, input int ul);
        @(negedge clk);
        cfg_count = {CNT_W'(c3), CNT_W'(c2), CNT_W'(c1), CNT_W'(c0)};
        cfg_len   = {LEN_W'(l3), LEN_W'(l2), LEN_W'(l1), LEN_W'(l0)};
        uni_count = CNT_W'(uc);
        uni_len   = LEN_W'(ul);
        #1;
    endtask

    // Main layout: 8x256 B, 2x2 KiB, 1x2 KiB -> sectors 0..7, 8..9, 10; size 0x2000
    task automatic cfg_main();
        set_cfg(8, 'h100, 2, 'h800, 1, 'h800, 0, 'h100, 0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 valid after reset",   longint'(res_valid), 0);
        check("R11 sector after reset",  longint'(sector), 0);
        check("R11 oor after reset",     longint'(oor), 0);
        check("R11 erasing after reset", longint'(erasing), 0);

        cfg_main();
        check("R7 main layout valid", longint'(cfg_err), 0);
        do_lookup("R11 empty map",     'h300,  0, 3,  'h100, 'h300,  0);
        do_lookup("R2 first byte",     'h000,  0, 0,  'h100, 'h000,  0);
        do_lookup("R3 base clear",     'h2FF,  0, 2,  'h100, 'h200,  0);
        do_lookup("R2 end region0",    'h7FF,  0, 7,  'h100, 'h700,  0);
        do_lookup("R2 start region1",  'h800,  0, 8,  'h800, 'h800,  0);
        do_lookup("R3 end region1",    'h17FF, 0, 9,  'h800, 'h1000, 0);
        do_lookup("R2 region2",        'h1ABC, 0, 10, 'h800, 'h1800, 0);
        @(negedge clk);
        check("R1 no valid when idle", longint'(res_valid), 0);
        check("R1 sector held",        longint'(sector), 10);
        do_lookup("R4 size limit",     'h2000, 1, 0, 0, 0, 0);
        do_lookup("R4 far offset",     'hFF_FFFF, 1, 0, 0, 0, 0);

        // R9 pending map
        do_mark('h350, 1'b0);
        do_mark('h1900, 1'b0);
        do_mark('h9000, 1'b0);
        do_lookup("R9 marked sector3",    'h300,  0, 3,  'h100, 'h300,  1);
        do_lookup("R9 unmarked sector4",  'h400,  0, 4,  'h100, 'h400,  0);
        do_lookup("R9 marked sector10",   'h1FFF, 0, 10, 'h800, 'h1800, 1);
        do_lookup("R9 oor never erasing", 'h9000, 1, 0, 0, 0, 0);
        // R10 clear
        do_clear();
        do_lookup("R10 cleared sector3",  'h300,  0, 3,  'h100, 'h300,  0);
        do_lookup("R10 cleared sector10", 'h1800, 0, 10, 'h800, 'h1800, 0);
        do_mark('h350, 1'b1);
        do_lookup("R10 clear beats mark", 'h300,  0, 3,  'h100, 'h300,  0);

        // R5 terminator: region1 count 0 hides regions 2 and 3
        set_cfg(8, 'h100, 0, 'h800, 1, 'h180, 5, 'h100, 0, 0);
        check("R5 bad region after end ignored", longint'(cfg_err), 0);
        do_lookup("R5 size ends at 0x800", 'h800, 1, 0, 0, 0, 0);
        do_lookup("R5 region0 still used", 'h7FF, 0, 7, 'h100, 'h700, 0);

        // R6 uniform fallback
        set_cfg(0, 'h100, 3, 'h100, 0, 0, 0, 0, 16, 'h1000);
        check("R6 uniform valid", longint'(cfg_err), 0);
        do_lookup("R6 uniform sector5", 'h5432, 0, 5, 'h1000, 'h5000, 0);
        do_lookup("R6 uniform last",    'hFFFF, 0, 15, 'h1000, 'hF000, 0);
        do_lookup("R6 uniform limit",   'h10000, 1, 0, 0, 0, 0);
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 4, 'h300);
        check("R7 uniform non-pow2", longint'(cfg_err), 1);

        // R7 length rules
        set_cfg(8, 'h100, 2, 'h180, 0, 0, 0, 0, 0, 0);
        check("R7 non-pow2 length", longint'(cfg_err), 1);
        set_cfg(1, 'h80, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R7 length below 256", longint'(cfg_err), 1);
        set_cfg(1, 'h100_0000, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R7 length 2^24", longint'(cfg_err), 1);
        set_cfg(1, 'h80_0000, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R7 length 2^23 legal", longint'(cfg_err), 0);

        // R8 alignment
        set_cfg(1, 'h100, 1, 'h800, 0, 0, 0, 0, 0, 0);
        check("R8 misaligned region1", longint'(cfg_err), 1);
        set_cfg(8, 'h100, 1, 'h800, 0, 0, 0, 0, 0, 0);
        check("R8 aligned region1", longint'(cfg_err), 0);

        repeat (3) @(negedge clk);
        check("R1 all results seen", longint'(exp_q.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule